// File: doc/BRIEF.md
# Overlapping 1101 Serial Sequence Detector

This block watches a serial stream that delivers one bit per clock and raises a flag whenever the four most recent bits, oldest first, were 1, 1, 0, 1. Matches may overlap: the final 1 of one match can serve as the first 1 of the next. Two independent state machines see the same input bit. The early flag comes from a four-state machine whose output depends on the current state and the incoming bit, so it rises in the same cycle as the closing 1. The late flag comes from a five-state machine whose output depends only on its state, so it rises one clock later and is a clean registered-state signal.

Designers pick the flag that suits the consumer. The early flag suits logic in the same clock domain that can tolerate a combinational path from the input. The late flag suits consumers that need a signal free of input-to-output paths. Reset is asynchronous and active low. It is expected to arrive already synchronised to `clk` for its release.

Top module: `seq1101_detect`

## Requirements
- R1: While `rst_n` is 0, both machines sit in their idle state and `hit_now` and `hit_late` are both 0, whatever `bit_in` does.
- R2: `hit_now` is 1 during a cycle exactly when the three bits clocked in since reset immediately before it were 1, 1, 0 (oldest first) and `bit_in` is 1 in that cycle.
- R3: `hit_late` is 1 in a cycle exactly when `hit_now` was 1 in the previous clock cycle. The late flag trails the early flag by one clock.
- R4: Overlapping matches are all reported: the stream 1,1,0,1,1,0,1 produces two flags on each output.
- R5: Neither output is ever 1 in two consecutive cycles.
- R6: A run of more than two 1s followed by 0,1 is reported once, at the closing 1, and a run of 1s alone never raises a flag.
- R7: A 0 arriving after 1,1,0 discards the partial match, so 1,1,0,0,1 raises no flag.
- R8: Asserting reset in the middle of a partial match discards it: 1,1,0, then reset, then 1 raises no flag.
- R9: The late machine uses five binary-coded states (idle=0 up to accept=4) and flags only in the accept state. The early machine uses four states coded 0 to 3 and flags only in state 3 with `bit_in` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge samples `bit_in` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_in | input | 1 | Serial data bit for the current cycle |
| hit_now | output | 1 | Same-cycle match flag (state and input dependent) |
| hit_late | output | 1 | Match flag one clock later (state dependent only) |

## Verification
The block has no tunable parameters, so the bench builds it in its single configuration. Together with a behavioural sliding-window model, that configuration reaches every state and arc of both machines. The directed streams cover the overlap case, long runs of 1s, a broken partial match and a reset taken in mid-match. A long pseudo-random stream then checks the fixed one-cycle offset between the two flags across many back-to-back and widely spaced matches.

// File: rtl/seq1101_pkg.sv
package seq1101_pkg;

  localparam int unsigned LATE_STW  = 3;
  localparam int unsigned EARLY_STW = 2;

  typedef enum logic [LATE_STW-1:0] {
    LS_IDLE  = 3'd0,
    LS_ONE   = 3'd1,
    LS_TWO   = 3'd2,
    LS_ZERO  = 3'd3,
    LS_MATCH = 3'd4
  } late_st_e;

  typedef enum logic [EARLY_STW-1:0] {
    ES_IDLE = 2'd0,
    ES_ONE  = 2'd1,
    ES_TWO  = 2'd2,
    ES_ZERO = 2'd3
  } early_st_e;

endpackage

// File: rtl/seq1101_late_fsm.sv
module seq1101_late_fsm
  import seq1101_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic flag
);

  late_st_e cur_q;
  late_st_e nxt_d;

  always_comb begin
    nxt_d = cur_q;
    unique case (cur_q)
      LS_IDLE:  nxt_d = bit_in ? LS_ONE   : LS_IDLE;
      LS_ONE:   nxt_d = bit_in ? LS_TWO   : LS_IDLE;
      LS_TWO:   nxt_d = bit_in ? LS_TWO   : LS_ZERO;
      LS_ZERO:  nxt_d = bit_in ? LS_MATCH : LS_IDLE;
      LS_MATCH: nxt_d = bit_in ? LS_TWO   : LS_IDLE;
      default:  nxt_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= LS_IDLE;
    end else begin
      cur_q <= nxt_d;
    end
  end

  assign flag = (cur_q == LS_MATCH);

endmodule

// File: rtl/seq1101_early_fsm.sv
module seq1101_early_fsm
  import seq1101_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic flag
);

  early_st_e cur_q;
  early_st_e nxt_d;
  logic      flag_d;

  always_comb begin
    nxt_d  = cur_q;
    flag_d = 1'b0;
    unique case (cur_q)
      ES_IDLE: nxt_d = bit_in ? ES_ONE : ES_IDLE;
      ES_ONE:  nxt_d = bit_in ? ES_TWO : ES_IDLE;
      ES_TWO:  nxt_d = bit_in ? ES_TWO : ES_ZERO;
      ES_ZERO: begin
        nxt_d  = bit_in ? ES_ONE : ES_IDLE;
        flag_d = bit_in;
      end
      default: nxt_d = ES_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= ES_IDLE;
    end else begin
      cur_q <= nxt_d;
    end
  end

  // Held low while reset is applied, even if the input is high.
  assign flag = flag_d & rst_n;

endmodule

// File: rtl/seq1101_detect.sv
module seq1101_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic hit_now,
  output logic hit_late
);

  seq1101_early_fsm u_early (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (bit_in),
    .flag   (hit_now)
  );

  seq1101_late_fsm u_late (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (bit_in),
    .flag   (hit_late)
  );

endmodule

// File: rtl/seq1101_detect_chk.sv
module seq1101_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_in,
  input logic hit_now,
  input logic hit_late
);

  // R1: both flags low whenever reset is applied
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r1: assert (!hit_now && !hit_late)
        else $error("reset flags not low");
    end
  end

  p_early_history_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |-> (bit_in && !$past(bit_in, 1) && $past(bit_in, 2) && $past(bit_in, 3)));

  p_late_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> hit_late);

  p_late_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_late |-> $past(hit_now));

  p_late_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_late |=> !hit_late);

  p_early_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> !hit_now);

endmodule

bind seq1101_detect seq1101_detect_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_in   (bit_in),
  .hit_now  (hit_now),
  .hit_late (hit_late)
);

// File: tb/seq1101_detect_bench.sv
module seq1101_detect_bench;

  logic clk;
  logic rst_n;
  logic bit_in;
  logic hit_now;
  logic hit_late;

  int checks;
  int errors;
  bit done;

  // behavioural model: window of the bits clocked since reset
  logic [2:0] win;
  int         nbits;
  logic       exp_late;
  logic       prev_late;
  int         early_hits;
  int         late_hits;

  seq1101_detect u_seq1101_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_in   (bit_in),
    .hit_now  (hit_now),
    .hit_late (hit_late)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    win = 3'b000;
    nbits = 0;
    exp_late = 1'b0;
    prev_late = 1'b0;
  endtask

  // one clock: drive at negedge, sample just before the rising edge
  task automatic step(input logic b, input string tag);
    logic exp_now;
    @(negedge clk);
    bit_in = b;
    #4;
    exp_now = rst_n && (nbits >= 3) && (win == 3'b110) && b;
    check(tag, "hit_now", hit_now, exp_now);
    check(tag, "hit_late", hit_late, rst_n ? exp_late : 1'b0);
    checks++;
    if (prev_late && hit_late) begin
      errors++;
      $display("FAIL R5 hit_late repeated: actual=1 expected=0 at %0t", $time);
    end
    prev_late = hit_late;
    if (hit_now) early_hits++;
    if (hit_late) late_hits++;
    @(posedge clk);
    if (rst_n) begin
      win = {win[1:0], b};
      nbits++;
      exp_late = exp_now;
    end else begin
      model_clear();
    end
  endtask

  task automatic apply_reset(input int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < cycles; i++) step(i[0], "R1");
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic send(input logic [15:0] pat, input int len, input string tag);
    for (int i = len - 1; i >= 0; i--) step(pat[i], tag);
  endtask

  task automatic expect_count(input string tag, input int e_now, input int e_late);
    check(tag, "early count", early_hits == e_now, 1'b1);
    if (early_hits != e_now) $display("FAIL %s early hits: actual=%0d expected=%0d", tag, early_hits, e_now);
    check(tag, "late count", late_hits == e_late, 1'b1);
    if (late_hits != e_late) $display("FAIL %s late hits: actual=%0d expected=%0d", tag, late_hits, e_late);
    early_hits = 0;
    late_hits = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    checks = 0;
    errors = 0;
    done = 1'b0;
    early_hits = 0;
    late_hits = 0;
    rst_n = 1'b0;
    bit_in = 1'b0;
    model_clear();

    // R1: reset with the input toggling, including a high input
    apply_reset(4);
    early_hits = 0; late_hits = 0;

    // R2 / R3: single match, then a trailing 0 lets the late flag show
    send(16'b11010, 5, "R2");
    expect_count("R2", 1, 1);

    // R4: overlapping matches
    send(16'b11011010, 8, "R4");
    expect_count("R4", 2, 2);

    // R6: long run of ones, then 0,1
    send(16'b1111110, 7, "R6");
    expect_count("R6", 0, 0);
    send(16'b10, 2, "R6");
    expect_count("R6", 1, 1);

    // R7: a second zero breaks the partial match
    send(16'b0110010, 7, "R7");
    expect_count("R7", 0, 0);

    // R8: reset in mid-match drops the history
    send(16'b0110, 4, "R8");
    apply_reset(2);
    early_hits = 0; late_hits = 0;
    send(16'b100, 3, "R8");
    expect_count("R8", 0, 0);

    // R9 / R3 / R5: long pseudo-random stream against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      step(lfsr[0] | lfsr[3], "R3");
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    check("R9", "saw matches", (early_hits > 0) && (early_hits == late_hits + (exp_late ? 1 : 0)), 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule